// File: doc/BRIEF.md
# Four-Register Sequencing Core

This block is a small single-issue processor that runs a short program held in an on-block instruction store. It has four 32-bit general registers, a word-addressed data store with a registered read, and ten operations. Each operation names two registers, A and B. When an operation writes a register, it always writes B. There is no flags register: the conditional branch compares two registers directly.

A host writes the program through a simple write port, normally while reset is held. It then releases reset and watches the output strobe. A system call presents register 0 on the output port for one cycle. A return operation stops the core. An encoding outside the defined set also stops the core and raises an illegal flag. After a stop, nothing moves until the next reset.

Top module: `quad_reg_core`

## Requirements
- R1: While rst_n is low, out_valid, halted and illegal are 0, all registers are 0 and the program index is 0. After release, execution starts at instruction 0.
- R2: Instruction fields are: opcode in bits [31:28], register A in [27:26], register B in [25:24], and a 16-bit constant K in [15:0]. Opcode 0 writes K, zero-extended, into B. Opcode 1 copies A into B.
- R3: Opcode 2 stores A at data address K. Opcode 3 loads data address K into B and takes two cycles. The data address is K modulo the data store depth, which is 64 words by default.
- R4: Opcode 4 writes B+A into B and opcode 5 writes B−A into B, both wrapping modulo 2^32.
- R5: Opcode 6 jumps to instruction K when A equals B and otherwise goes on to the next instruction. Opcode 7 always jumps to instruction K.
- R6: Opcode 9 with K equal to 3 puts register 0 on out_data with out_valid high for exactly the one cycle after it executes.
- R7: Opcode 8 sets halted one cycle after it executes. While halted, the program index and the registers hold and out_valid stays 0 until reset.
- R8: Opcodes 10 to 15, and opcode 9 with K other than 3, set both halted and illegal one cycle after they execute, and produce no output.
- R9: Every operation other than a load completes in one cycle.
- R10: With imem_we high at a rising edge, imem_wdata is written into instruction slot imem_addr, whether or not reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | IMEM_AW | Instruction slot to write |
| imem_wdata | input | 32 | Instruction word to write |
| out_data | output | DATA_W | Register 0 value from the last system call |
| out_valid | output | 1 | One-cycle strobe marking out_data |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an undefined encoding |

## Verification
Every operation takes one clock edge, except a load, which takes two. The output strobe therefore shows up on the edge that executes the system call, and halted shows up on the edge that executes the return or the bad encoding. The bench counts rising edges from the release of reset and samples at the following falling edge. For each program it works out the edge at which every output pulse and the halt are due, and compares both the values and the edge numbers. After each stop it watches a few more cycles to confirm that the core stays silent.

// File: rtl/quad_core_pkg.sv
// Shared definitions for the four-register core: field positions, opcodes
// and the decoded-instruction record. Assumes a fixed 32-bit instruction.
package quad_core_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_LSB = 28;
    localparam int RA_LSB  = 26;
    localparam int RB_LSB  = 24;
    localparam int K_W     = 16;

    typedef enum logic [3:0] {
        OP_LDI = 4'd0,
        OP_MOV = 4'd1,
        OP_ST  = 4'd2,
        OP_LD  = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_BEQ = 4'd6,
        OP_JMP = 4'd7,
        OP_RET = 4'd8,
        OP_SYS = 4'd9
    } opcode_e;

    localparam logic [3:0]     LAST_OPC    = 4'd9;
    localparam logic [K_W-1:0] SYS_EMIT_R0 = 16'd3;

    typedef struct packed {
        opcode_e        op;
        logic           bad;
        logic [1:0]     ra;
        logic [1:0]     rb;
        logic [K_W-1:0] k;
    } dec_t;

endpackage

// File: rtl/qc_imem.sv
// Instruction store: one synchronous write port for the host and one
// combinational read port for fetch. Contents have no reset.
module qc_imem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Host write of one instruction word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch read, same cycle.
    assign rdata = mem[raddr];
endmodule

// File: rtl/qc_decode.sv
// Instruction decoder: splits the word into fields and flags encodings
// outside the defined set (unknown opcode or unsupported call code).
module qc_decode
    import quad_core_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [3:0] opc_raw;
    logic       unused_spare;

    assign opc_raw      = instr[OPC_LSB +: 4];
    assign unused_spare = ^instr[23:16];

    // Field extraction and legality check.
    always_comb begin
        dec.op  = opcode_e'(opc_raw);
        dec.ra  = instr[RA_LSB +: 2];
        dec.rb  = instr[RB_LSB +: 2];
        dec.k   = instr[K_W-1:0];
        dec.bad = (opc_raw > LAST_OPC) ||
                  ((opc_raw == OP_SYS) && (instr[K_W-1:0] != SYS_EMIT_R0));
    end
endmodule

// File: rtl/qc_regfile.sv
// General register file: two indexed read ports, a fixed read of
// register 0 for the output call, one write port; cleared by reset.
module qc_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [DW-1:0]           rdata_a,
    output logic [DW-1:0]           rdata_b,
    output logic [DW-1:0]           rdata_0
);
    localparam int AW = $clog2(NREG);

    logic [NREG-1:0][DW-1:0] regs_q;
    logic [NREG-1:0]         wen;

    // One write-enable per register.
    for (genvar g = 0; g < NREG; g++) begin : g_wen
        assign wen[g] = we && (waddr == AW'(g));
    end

    // Register update with synchronous clear.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)      regs_q[i] <= '0;
            else if (wen[i]) regs_q[i] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
    assign rdata_0 = regs_q[0];
endmodule

// File: rtl/qc_dmem.sv
// Data store: single address, synchronous write and registered read
// (read data is valid the cycle after the address). No reset.
module qc_dmem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write and registered read on the same address.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/quad_reg_core.sv
// Four-register sequencing core. Fetches from the instruction store at
// pc_q, executes one operation per cycle (loads take two), and stops on a
// return or an undefined encoding. Assumes IMEM_AW and DMEM_AW <= 16.
module quad_reg_core
    import quad_core_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_wdata,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_valid,
    output logic               halted,
    output logic               illegal
);
    localparam int NREG = 4;
    localparam int RAW  = $clog2(NREG);

    logic [IMEM_AW-1:0] pc_q, pc_nxt;
    logic               load_wait_q, halted_q, illegal_q;
    logic [INSTR_W-1:0] instr;
    dec_t               dec;
    logic [DATA_W-1:0]  ra_val, rb_val, r0_val, dm_rdata;
    logic               rf_we, dm_we;
    logic [DATA_W-1:0]  rf_wdata;
    logic               go_ret, go_bad, go_emit, go_load;
    logic               unused_k;

    assign unused_k = ^dec.k;

    qc_imem #(.AW(IMEM_AW), .DW(INSTR_W)) imem_i (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_addr),
        .wdata (imem_wdata),
        .raddr (pc_q),
        .rdata (instr)
    );

    qc_decode dec_i (
        .instr (instr),
        .dec   (dec)
    );

    qc_regfile #(.NREG(NREG), .DW(DATA_W)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (RAW'(dec.rb)),
        .wdata   (rf_wdata),
        .raddr_a (RAW'(dec.ra)),
        .raddr_b (RAW'(dec.rb)),
        .rdata_a (ra_val),
        .rdata_b (rb_val),
        .rdata_0 (r0_val)
    );

    qc_dmem #(.AW(DMEM_AW), .DW(DATA_W)) dm_i (
        .clk   (clk),
        .we    (dm_we),
        .addr  (dec.k[DMEM_AW-1:0]),
        .wdata (ra_val),
        .rdata (dm_rdata)
    );

    // Execute: register write, store, next index and stop conditions.
    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = ra_val;
        dm_we    = 1'b0;
        pc_nxt   = pc_q + 1'b1;
        go_ret   = 1'b0;
        go_bad   = 1'b0;
        go_emit  = 1'b0;
        go_load  = 1'b0;
        if (halted_q) begin
            pc_nxt = pc_q;
        end else if (load_wait_q) begin
            rf_we    = 1'b1;
            rf_wdata = dm_rdata;
        end else if (dec.bad) begin
            go_bad = 1'b1;
            pc_nxt = pc_q;
        end else begin
            case (dec.op)
                OP_LDI: begin
                    rf_we    = 1'b1;
                    rf_wdata = {{(DATA_W-K_W){1'b0}}, dec.k};
                end
                OP_MOV: begin
                    rf_we    = 1'b1;
                    rf_wdata = ra_val;
                end
                OP_ST:  dm_we = 1'b1;
                OP_LD: begin
                    go_load = 1'b1;
                    pc_nxt  = pc_q;
                end
                OP_ADD: begin
                    rf_we    = 1'b1;
                    rf_wdata = rb_val + ra_val;
                end
                OP_SUB: begin
                    rf_we    = 1'b1;
                    rf_wdata = rb_val - ra_val;
                end
                OP_BEQ: if (ra_val == rb_val) pc_nxt = dec.k[IMEM_AW-1:0];
                OP_JMP: pc_nxt = dec.k[IMEM_AW-1:0];
                OP_RET: begin
                    go_ret = 1'b1;
                    pc_nxt = pc_q;
                end
                OP_SYS: go_emit = 1'b1;
                default: begin
                    go_bad = 1'b1;
                    pc_nxt = pc_q;
                end
            endcase
        end
    end

    // Control state and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= '0;
            load_wait_q <= 1'b0;
            halted_q    <= 1'b0;
            illegal_q   <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
        end else begin
            pc_q        <= pc_nxt;
            load_wait_q <= go_load;
            out_valid   <= go_emit;
            if (go_emit) out_data <= r0_val;
            if (go_ret || go_bad) halted_q <= 1'b1;
            if (go_bad) illegal_q <= 1'b1;
        end
    end

    assign halted  = halted_q;
    assign illegal = illegal_q;
endmodule

// File: rtl/qc_core_chk.sv
// Property checker for quad_reg_core: stop behaviour and load timing.
// Attached to every instance of the core through the bind below.
module qc_core_chk #(
    parameter int PC_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halted,
    input logic            illegal,
    input logic            out_valid,
    input logic [PC_W-1:0] pc_q,
    input logic            load_wait_q
);
    // R7: once stopped, the core stays stopped.
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7: the program index holds while stopped.
    a_r7_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_q));

    // R7: no output strobe while stopped.
    a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !out_valid);

    // R8: the illegal flag only appears together with a stop.
    a_r8_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R3: the load wait cycle keeps the program index.
    a_r3_load_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        load_wait_q |-> $stable(pc_q));

    // R3: a load waits exactly one extra cycle.
    a_r3_load_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
        load_wait_q |=> !load_wait_q);
endmodule

bind quad_reg_core qc_core_chk #(.PC_W(IMEM_AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .halted      (halted),
    .illegal     (illegal),
    .out_valid   (out_valid),
    .pc_q        (pc_q),
    .load_wait_q (load_wait_q)
);

// File: tb/quad_reg_core_tb_top.sv
// Directed bench for quad_reg_core: one task per program scenario.
module quad_reg_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IMEM_AW    = 6;
    localparam int WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               imem_we = 1'b0;
    logic [IMEM_AW-1:0] imem_addr = '0;
    logic [31:0]        imem_wdata = '0;
    logic [31:0]        out_data;
    logic               out_valid, halted, illegal;

    int errors = 0;
    int checks = 0;
    int ticks  = 0;

    logic [31:0] prog [16];
    int          prog_len;
    logic [31:0] out_val [8];
    int          out_cyc [8];
    int          nout;
    int          halt_cyc;

    quad_reg_core #(.DATA_W(32), .IMEM_AW(IMEM_AW), .DMEM_AW(6)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .halted     (halted),
        .illegal    (illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        ticks++;
        if (ticks > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog: cycles=%0d expected below %0d", ticks, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] enc(int op, int a, int b, int k);
        logic [3:0]  o = 4'(op);
        logic [1:0]  ra = 2'(a);
        logic [1:0]  rb = 2'(b);
        logic [15:0] kk = 16'(k);
        return {o, ra, rb, 8'h00, kk};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Hold reset, write the program, check the reset state, release.
    task automatic start_prog();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < prog_len; i++) begin
            imem_we    = 1'b1;
            imem_addr  = IMEM_AW'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        @(negedge clk);
        check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check("R1", "halted in reset", 32'(halted), 32'd0);
        check("R1", "illegal in reset", 32'(illegal), 32'd0);
        rst_n = 1'b1;
    endtask

    // Count edges from release; record output pulses and the halt edge,
    // then watch idle cycles after the halt.
    task automatic run_prog(int idle);
        int cyc = 0;
        nout     = 0;
        halt_cyc = -1;
        while (!halted && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (out_valid) begin
                if (nout < 8) begin
                    out_val[nout] = out_data;
                    out_cyc[nout] = cyc;
                end
                nout++;
            end
            if (halted) halt_cyc = cyc;
        end
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            if (out_valid) nout++;
            if (!halted) halt_cyc = -2;
        end
    endtask

    task automatic test_main_taken();
        prog_len = 11;
        prog[0]  = enc(0, 0, 0, 10);
        prog[1]  = enc(0, 0, 1, 15);
        prog[2]  = enc(4, 0, 1, 0);
        prog[3]  = enc(2, 1, 0, 16'h1000);
        prog[4]  = enc(3, 0, 0, 16'h1000);
        prog[5]  = enc(0, 0, 1, 25);
        prog[6]  = enc(6, 0, 1, 9);
        prog[7]  = enc(2, 1, 0, 16'h1000);
        prog[8]  = enc(7, 0, 0, 10);
        prog[9]  = enc(9, 0, 0, 3);
        prog[10] = enc(8, 0, 0, 0);
        start_prog();
        run_prog(4);
        check("R5", "taken branch output count", 32'(nout), 32'd1);
        check("R4", "sum through store/load", out_val[0], 32'd25);
        check("R6", "output edge", 32'(out_cyc[0]), 32'd9);
        check("R7", "halt edge", 32'(halt_cyc), 32'd10);
        check("R8", "illegal after normal return", 32'(illegal), 32'd0);
    endtask

    task automatic test_main_not_taken();
        prog_len = 11;
        prog[0]  = enc(0, 0, 0, 10);
        prog[1]  = enc(0, 0, 1, 15);
        prog[2]  = enc(4, 0, 1, 0);
        prog[3]  = enc(2, 1, 0, 16'h1000);
        prog[4]  = enc(3, 0, 0, 16'h1000);
        prog[5]  = enc(0, 0, 1, 26);
        prog[6]  = enc(6, 0, 1, 9);
        prog[7]  = enc(2, 1, 0, 16'h1000);
        prog[8]  = enc(7, 0, 0, 10);
        prog[9]  = enc(9, 0, 0, 3);
        prog[10] = enc(8, 0, 0, 0);
        start_prog();
        run_prog(4);
        check("R5", "not-taken branch skips output", 32'(nout), 32'd0);
        check("R9", "halt edge via jump", 32'(halt_cyc), 32'd11);
    endtask

    task automatic test_arith_wrap();
        prog_len = 8;
        prog[0] = enc(0, 0, 0, 3);
        prog[1] = enc(5, 0, 1, 0);
        prog[2] = enc(1, 1, 0, 0);
        prog[3] = enc(9, 0, 0, 3);
        prog[4] = enc(0, 0, 2, 5);
        prog[5] = enc(4, 2, 0, 0);
        prog[6] = enc(9, 0, 0, 3);
        prog[7] = enc(8, 0, 0, 0);
        start_prog();
        run_prog(2);
        check("R4", "output count", 32'(nout), 32'd2);
        check("R4", "subtract wraps below zero", out_val[0], 32'hFFFF_FFFD);
        check("R2", "move copied into R0", out_val[0], 32'hFFFF_FFFD);
        check("R4", "add wraps past top", out_val[1], 32'd2);
        check("R9", "second output edge", 32'(out_cyc[1]), 32'd7);
        check("R7", "halt edge", 32'(halt_cyc), 32'd8);
    endtask

    task automatic test_load_timing();
        prog_len = 5;
        prog[0] = enc(0, 0, 1, 42);
        prog[1] = enc(2, 1, 0, 16'h1003);
        prog[2] = enc(3, 0, 0, 16'h0003);
        prog[3] = enc(9, 0, 0, 3);
        prog[4] = enc(8, 0, 0, 0);
        start_prog();
        run_prog(2);
        check("R3", "aliased address load value", out_val[0], 32'd42);
        check("R3", "load adds one cycle", 32'(out_cyc[0]), 32'd5);
        check("R7", "halt edge", 32'(halt_cyc), 32'd6);
    endtask

    task automatic test_bad_opcode();
        prog_len = 4;
        prog[0] = enc(0, 0, 0, 7);
        prog[1] = enc(9, 0, 0, 3);
        prog[2] = 32'hC000_0000;
        prog[3] = enc(9, 0, 0, 3);
        start_prog();
        run_prog(8);
        check("R6", "output before bad opcode", out_val[0], 32'd7);
        check("R8", "only one output", 32'(nout), 32'd1);
        check("R8", "halt edge on bad opcode", 32'(halt_cyc), 32'd3);
        check("R8", "illegal raised", 32'(illegal), 32'd1);
    endtask

    task automatic test_bad_call();
        prog_len = 2;
        prog[0] = enc(9, 0, 0, 5);
        prog[1] = enc(9, 0, 0, 3);
        start_prog();
        run_prog(4);
        check("R8", "bad call gives no output", 32'(nout), 32'd0);
        check("R8", "bad call halt edge", 32'(halt_cyc), 32'd1);
        check("R8", "bad call illegal", 32'(illegal), 32'd1);
    endtask

    task automatic test_return_freeze();
        prog_len = 3;
        prog[0] = enc(8, 0, 0, 0);
        prog[1] = enc(9, 0, 0, 3);
        prog[2] = enc(9, 0, 0, 3);
        start_prog();
        run_prog(10);
        check("R7", "return halt edge and hold", 32'(halt_cyc), 32'd1);
        check("R7", "no output after return", 32'(nout), 32'd0);
        check("R7", "illegal stays low", 32'(illegal), 32'd0);
    endtask

    task automatic test_reload_in_reset();
        // R10: new program written under reset replaces the old one.
        prog_len = 2;
        prog[0] = enc(9, 0, 0, 3);
        prog[1] = enc(8, 0, 0, 0);
        start_prog();
        run_prog(2);
        check("R10", "reloaded program output count", 32'(nout), 32'd1);
        check("R1", "R0 cleared by reset", out_val[0], 32'd0);
        check("R10", "reloaded program halt edge", 32'(halt_cyc), 32'd2);
    endtask

    initial begin
        test_main_taken();
        test_main_not_taken();
        test_arith_wrap();
        test_load_timing();
        test_bad_opcode();
        test_bad_call();
        test_return_freeze();
        test_reload_in_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule